// File: doc/BRIEF.md
# Command Ring Consumer with Completion Events

This block is the consuming side of a command ring. Commands are 16-byte transfer request blocks (TRBs) held in a small internal ring memory. A producer fills the memory through a write port and then pulses a doorbell. The consumer walks the ring from its dequeue index. It takes a TRB only while the TRB's cycle bit equals the consumer's own cycle state. When it meets a TRB that does not match, it stops and waits for the next doorbell.

The ring is made of segments. A link TRB sends the dequeue index to the start of another segment, and a link TRB with its toggle flag set also inverts the consumer cycle state. For every no-op command, the block writes a completion event into an output FIFO and raises an interrupt. The event holds the index of the command TRB, a success completion code and the event-ring producer cycle bit. Any other command type is consumed and produces no event.

Top module: `trb_cmd_consumer`

## Requirements
- R1: After reset, `irq` is 0, `ev_valid` is 0, the consumer cycle state is 1, the dequeue index is 0 and the event producer cycle bit is 1. The first TRB processed after reset is entry 0, and it is processed only if its cycle bit is 1.
- R2: TRB layout is 128 bits. Bit 96 is the cycle bit, bit 97 is the toggle flag, bit 100 is the chain bit, bits 111:106 are the type, and bits [ADDR_W-1:0] hold the link target index. Type 23 is a no-op command and type 6 is a link. The chain bit does not change how a command is handled.
- R3: A TRB is processed only when its cycle bit equals the consumer cycle state. At the first TRB that does not match, the consumer stops and posts no event for it.
- R4: A doorbell pulse starts a pass when the consumer is idle. Writes alone do not start a pass. A doorbell that arrives while a pass is running is remembered, and one more pass starts after the current one stops.
- R5: A link TRB moves the dequeue index to its target index. If its toggle flag is set, the consumer cycle state is inverted; otherwise the state is kept.
- R6: A no-op command posts one event with `ev_ptr` equal to the TRB's index and `ev_code` equal to 1 (success). Events appear in the order the commands were consumed.
- R7: `ev_cycle` carries the event producer cycle bit. This bit starts at 1 and flips after every EV_RING_LEN events.
- R8: A TRB of any other type is consumed (the dequeue index advances) and posts no event.
- R9: `irq` rises on every event post and stays high until `irq_clr`. When a post and `irq_clr` fall in the same cycle, `irq` stays 1.
- R10: When the event FIFO is full, the consumer stalls without losing a command. `ev_pop` while the FIFO is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Producer write strobe |
| wr_idx | input | ADDR_W | Ring entry to write |
| wr_trb | input | 128 | TRB to write |
| doorbell | input | 1 | Command-ring doorbell pulse |
| ev_pop | input | 1 | Remove the head event |
| irq_clr | input | 1 | Clear the interrupt |
| ev_valid | output | 1 | Event FIFO is not empty |
| ev_ptr | output | ADDR_W | Index of the completed command TRB |
| ev_code | output | 8 | Completion code |
| ev_cycle | output | 1 | Event producer cycle bit |
| irq | output | 1 | Interrupt |

## Verification
Two pairs of functions can land in the same cycle, and the bench forces each pair at an exact clock edge. In the first, a doorbell and a producer write to the next entry arrive while the consumer is reading that same entry and finding it not yet owned. The test is judged a pass only if the remembered doorbell causes a second pass that posts the new command's event. In the second, `irq_clr` is driven into the exact cycle in which a no-op posts its event, and the test expects `irq` to stay high.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int TRB_W      = 128;
  localparam int CYC_BIT    = 96;
  localparam int TOG_BIT    = 97;
  localparam int CHAIN_BIT  = 100;
  localparam int TYPE_LO    = 106;
  localparam int TYPE_W     = 6;
  localparam logic [TYPE_W-1:0] TYPE_LINK = 6'd6;
  localparam logic [TYPE_W-1:0] TYPE_NOOP = 6'd23;
  localparam logic [7:0] CODE_SUCCESS = 8'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVAL  = 2'd2
  } cons_state_t;
endpackage

// File: rtl/trb_ring_mem.sv
module trb_ring_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  // Single write port, registered read: a same-address write returns old data.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/trb_evt_fifo.sv
module trb_evt_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 14,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             valid,
  output logic             full
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_pop;

  assign do_pop = pop && (cnt != '0);
  assign valid  = (cnt != '0);
  assign full   = (cnt == CW'(DEPTH));
  assign dout   = slots[rp];

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !do_pop) cnt <= cnt + 1'b1;
      else if (!push && do_pop) cnt <= cnt - 1'b1;
    end
  end

  // R10: the consumer never pushes into a full FIFO
  p_push_not_full_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R10: occupancy stays within the storage
  p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R10: a pop on an empty FIFO leaves it empty
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (!valid && pop && !push) |=> !valid);
endmodule

// File: rtl/trb_cmd_consumer.sv
module trb_cmd_consumer
  import trb_pkg::*;
#(
  parameter int RING_DEPTH  = 32,
  parameter int FIFO_DEPTH  = 4,
  parameter int EV_RING_LEN = 4,
  localparam int ADDR_W = $clog2(RING_DEPTH),
  localparam int EV_W   = 1 + 8 + ADDR_W,
  localparam int EVC_W  = (EV_RING_LEN > 1) ? $clog2(EV_RING_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [TRB_W-1:0]  wr_trb,
  input  logic              doorbell,
  input  logic              ev_pop,
  input  logic              irq_clr,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_ptr,
  output logic [7:0]        ev_code,
  output logic              ev_cycle,
  output logic              irq
);
  cons_state_t       state;
  logic [ADDR_W-1:0] deq;
  logic              ccs;
  logic              db_pend;
  logic              ev_pcs;
  logic [EVC_W-1:0]  ev_cnt;
  logic [TRB_W-1:0]  trb;
  logic              owned, is_link, is_noop, tog;
  logic              ev_push, fifo_full;
  logic [EV_W-1:0]   ev_din, ev_dout;
  logic              unused_bits;

  trb_ring_mem #(.DEPTH(RING_DEPTH), .WIDTH(TRB_W)) u_ring (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_trb),
    .raddr(deq), .rdata(trb)
  );

  assign owned   = (trb[CYC_BIT] == ccs);
  assign is_link = (trb[TYPE_LO +: TYPE_W] == TYPE_LINK);
  assign is_noop = (trb[TYPE_LO +: TYPE_W] == TYPE_NOOP);
  assign tog     = trb[TOG_BIT];
  assign ev_push = (state == ST_EVAL) && owned && is_noop && !fifo_full;
  assign ev_din  = {ev_pcs, CODE_SUCCESS, deq};
  assign unused_bits = ^{trb[TRB_W-1:TYPE_LO+TYPE_W], trb[TYPE_LO-1:TOG_BIT+1],
                         trb[CYC_BIT-1:ADDR_W]};

  trb_evt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(EV_W)) u_evq (
    .clk(clk), .rst(rst), .push(ev_push), .din(ev_din), .pop(ev_pop),
    .dout(ev_dout), .valid(ev_valid), .full(fifo_full)
  );

  assign ev_cycle = ev_dout[EV_W-1];
  assign ev_code  = ev_dout[ADDR_W +: 8];
  assign ev_ptr   = ev_dout[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      deq     <= '0;
      ccs     <= 1'b1;
      db_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (doorbell) state <= ST_FETCH;
        ST_FETCH: begin
          state <= ST_EVAL;
          if (doorbell) db_pend <= 1'b1;
        end
        default: begin
          if (doorbell) db_pend <= 1'b1;
          if (!owned) begin
            state   <= (db_pend || doorbell) ? ST_FETCH : ST_IDLE;
            db_pend <= 1'b0;
          end else if (is_link) begin
            deq   <= trb[ADDR_W-1:0];
            if (tog) ccs <= ~ccs;
            state <= ST_FETCH;
          end else if (!(is_noop && fifo_full)) begin
            deq   <= deq + 1'b1;
            state <= ST_FETCH;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_pcs <= 1'b1;
      ev_cnt <= '0;
      irq    <= 1'b0;
    end else begin
      if (ev_push) begin
        if (ev_cnt == EVC_W'(EV_RING_LEN - 1)) begin
          ev_cnt <= '0;
          ev_pcs <= ~ev_pcs;
        end else begin
          ev_cnt <= ev_cnt + 1'b1;
        end
      end
      if (ev_push) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R3: an unowned TRB ends evaluation
  p_stop_unowned_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL && !owned) |=> (state != ST_EVAL));
  // R5: a followed link moves the dequeue index to its target
  p_link_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL && owned && is_link) |=> (deq == $past(trb[ADDR_W-1:0])));
  // R5: a toggling link inverts the consumer cycle state
  p_link_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL && owned && is_link && tog) |=> (ccs != $past(ccs)));
  // R7: producer cycle flips at the end of each event-ring lap
  p_pcs_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_push && ev_cnt == EVC_W'(EV_RING_LEN - 1)) |=> (ev_pcs != $past(ev_pcs)));
  // R9: a posted event raises the interrupt
  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    ev_push |=> irq);
  // R9: the interrupt holds until cleared
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

// File: tb/test_trb_cmd_consumer.sv
module test_trb_cmd_consumer;
  localparam int AW  = 5;
  localparam int EVL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0;
  logic [127:0] wr_trb = '0;
  logic doorbell = 1'b0, ev_pop = 1'b0, irq_clr = 1'b0;
  logic ev_valid, ev_cycle, irq;
  logic [AW-1:0] ev_ptr;
  logic [7:0] ev_code;

  int checks = 0, fails = 0, ev_n = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trb_cmd_consumer #(.RING_DEPTH(32), .FIFO_DEPTH(4), .EV_RING_LEN(EVL)) i_trb_cmd_consumer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_trb(wr_trb),
    .doorbell(doorbell), .ev_pop(ev_pop), .irq_clr(irq_clr),
    .ev_valid(ev_valid), .ev_ptr(ev_ptr), .ev_code(ev_code),
    .ev_cycle(ev_cycle), .irq(irq)
  );

  // record: idx(5) type(6) cycle toggle chain target(5)
  localparam logic [18:0] PROG [16] = '{
    {5'd0, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},  {5'd1, 6'd23, 1'b1, 1'b0, 1'b1, 5'd0},
    {5'd2, 6'd9,  1'b1, 1'b0, 1'b1, 5'd0},  {5'd3, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},
    {5'd4, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},  {5'd5, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},
    {5'd6, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},  {5'd7, 6'd6,  1'b1, 1'b0, 1'b0, 5'd16},
    {5'd16, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0}, {5'd17, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},
    {5'd18, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0}, {5'd19, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},
    {5'd20, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0}, {5'd21, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0},
    {5'd22, 6'd23, 1'b1, 1'b0, 1'b0, 5'd0}, {5'd23, 6'd6,  1'b1, 1'b1, 1'b0, 5'd0}
  };
  localparam logic [4:0] EXP_PTR [13] = '{5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6,
    5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input int typ, input bit c, input bit t,
                     input bit ch, input int tgt);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = AW'(idx); wr_trb = '0;
    wr_trb[AW-1:0] = AW'(tgt); wr_trb[96] = c; wr_trb[97] = t;
    wr_trb[100] = ch; wr_trb[111:106] = 6'(typ);
    wr_trb[95:64] = 32'h5a5a_0f0f;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ring_bell();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic expect_event(input string req, input int ptr);
    int waited = 0;
    while (!ev_valid && waited < 100) begin @(negedge clk); waited++; end
    ev_n++;
    check({req, " valid"}, 32'(ev_valid), 32'd1);
    check({req, " ptr"}, 32'(ev_ptr), 32'(ptr));
    check({"R6 code"}, 32'(ev_code), 32'd1);
    check({"R7 cycle"}, 32'(ev_cycle), ((((ev_n - 1) / EVL) % 2) == 0) ? 32'd1 : 32'd0);
    ev_pop = 1'b1;
    @(negedge clk);
    ev_pop = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    idle_wait(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 ev_valid after reset", 32'(ev_valid), 32'd0);
    for (int i = 0; i < 32; i++) put(i, 0, 1'b0, 1'b0, 1'b0, 0);
    for (int i = 0; i < 16; i++)
      put(int'(PROG[i][18:14]), int'(PROG[i][13:8]), PROG[i][7], PROG[i][6],
          PROG[i][5], int'(PROG[i][4:0]));
    idle_wait(10);
    check("R4 no pass without doorbell", 32'(ev_valid), 32'd0);
    ring_bell();
    idle_wait(40);
    check("R10 stalled with full FIFO", 32'(ev_valid), 32'd1);
    check("R9 irq raised", 32'(irq), 32'd1);
    // R2 R5 R6 R8 R10: walk both segments, chained and other-type entries
    for (int i = 0; i < 13; i++) expect_event("R6 ring walk", int'(EXP_PTR[i]));
    idle_wait(20);
    check("R3 stop at unowned entry 0 after toggle", 32'(ev_valid), 32'd0);

    // R5: cycle state was inverted, so an entry with cycle 0 is now owned
    put(0, 23, 1'b0, 1'b0, 1'b0, 0);
    ring_bell();
    expect_event("R5 toggled ownership", 0);
    idle_wait(10);
    check("R3 entry 1 with old cycle not taken", 32'(ev_valid), 32'd0);

    // R4: doorbell and write land while entry 2 is being found unowned
    put(1, 23, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd2; wr_trb = '0; wr_trb[96] = 1'b0;
    wr_trb[111:106] = 6'd23; doorbell = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; doorbell = 1'b0;
    expect_event("R4 first pass", 1);
    expect_event("R4 remembered doorbell", 2);

    // R9: clear alone, then clear in the post cycle
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R9 irq cleared", 32'(irq), 32'd0);
    put(3, 23, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R9 set wins over clear", 32'(irq), 32'd1);
    expect_event("R9 event", 3);

    // R10: pop on empty is ignored
    idle_wait(10);
    @(negedge clk); ev_pop = 1'b1;
    @(negedge clk); ev_pop = 1'b0;
    check("R10 empty pop keeps empty", 32'(ev_valid), 32'd0);
    put(4, 23, 1'b0, 1'b0, 1'b0, 0);
    ring_bell();
    expect_event("R10 after empty pop", 4);
    idle_wait(10);
    check("R10 no phantom event", 32'(ev_valid), 32'd0);

    // R1: reset restores cycle state 1, index 0, producer cycle 1
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after second reset", 32'(irq), 32'd0);
    check("R1 ev_valid after second reset", 32'(ev_valid), 32'd0);
    put(0, 23, 1'b1, 1'b0, 1'b0, 0);
    put(1, 23, 1'b0, 1'b0, 1'b0, 0);
    ev_n = 0;
    ring_bell();
    expect_event("R1 restart at entry 0", 0);
    idle_wait(10);
    check("R1 entry 1 with cycle 0 not owned", 32'(ev_valid), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule